// File: doc/BRIEF.md
# Instruction Prefix Scanner and Size Resolver

This block sits at the front of an instruction decoder. It takes one instruction byte per cycle over a valid/ready handshake. It absorbs the legacy prefix bytes and an optional register-extension prefix that come before the opcode. When the first non-prefix byte arrives, the block presents that byte as the opcode, together with the settings collected from the prefixes: segment override, lock and repeat flags, resolved operand and address sizes, and the four extension bits.

A static `mode64` input selects between the 32-bit and the 64-bit operating mode. The outputs stay registered and stable, with `op_valid` high, until the next stage takes them with `out_ready`. After each opcode the collected prefix state returns to its defaults, so the next instruction starts clean.

Size codes on `op_size` and `addr_size`: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.

Top module: `pfx_scanner`

## Requirements
- R1: While `op_valid` is high and `out_ready` is low, `in_ready` is low and every opcode-side output holds its value. The cycle after `op_valid` and `out_ready` are both high, `op_valid` is low.
- R2: A prefix byte never raises `op_valid`. A non-prefix byte accepted at a clock edge makes `op_valid` high after that edge, with `op_byte` equal to the byte.
- R3: Segment prefix bytes map to codes as follows: 0x26→0, 0x2E→1, 0x36→2, 0x3E→3, 0x64→4, 0x65→5. The last segment prefix seen sets `seg_sel` and raises `seg_ovr`. With no segment prefix, `seg_ovr` is 0 and `seg_sel` is 3.
- R4: Byte 0xF0 sets `lock_seen`. Byte 0xF2 or 0xF3 sets `rep_seen`.
- R5: For a non-byte opcode in 32-bit mode, the operand size is 16 bits when a 0x66 prefix is present and 32 bits otherwise. In 64-bit mode without the wide bit, the same rule applies.
- R6: In 32-bit mode the address size is 32 bits, or 16 bits with a 0x67 prefix. In 64-bit mode it is 64 bits, or 32 bits with 0x67.
- R7: In 64-bit mode, a byte 0x40–0x4F is an extension prefix. Its bits 3,2,1,0 drive `ext_wide`, `ext_reg`, `ext_idx` and `ext_base`. When `ext_wide` is set on a non-byte opcode, the operand size is 64 bits, even if 0x66 is present.
- R8: In 32-bit mode, a byte 0x40–0x4F is an opcode, and all four extension outputs are 0.
- R9: An extension prefix followed by any other prefix is discarded, so its bits read 0. A later extension prefix replaces an earlier one.
- R10: Byte-class opcodes report an operand size of 8 bits whatever prefixes come before them. The byte-class opcodes are 0x88, 0x8A, 0xC6, 0xA0, 0xA2, 0xB0–0xB7, and any opcode below 0x40 whose low three bits are 0, 2 or 4.
- R11: Prefix state does not carry over: the instruction after an opcode starts from the defaults.
- R12: After reset, `op_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode; static |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| op_valid | output | 1 | Opcode and attributes available |
| op_byte | output | 8 | First opcode byte |
| out_ready | input | 1 | Downstream accepts the opcode |
| seg_ovr | output | 1 | A segment prefix was present |
| seg_sel | output | 3 | Selected segment code |
| lock_seen | output | 1 | Lock prefix present |
| rep_seen | output | 1 | Repeat prefix present |
| op_size | output | 2 | Resolved operand size code |
| addr_size | output | 2 | Resolved address size code |
| ext_wide | output | 1 | Extension wide bit |
| ext_reg | output | 1 | Extension bit for the reg field |
| ext_idx | output | 1 | Extension bit for the index field |
| ext_base | output | 1 | Extension bit for the base/rm field |

## Verification
The assertions take `mode64` as constant between resets. They also take `out_ready` as meaningful only while `op_valid` is high. Under these conditions the mode-dependent checks, such as no 64-bit sizes and no extension bits in 32-bit mode, hold for every opcode. The bench changes the mode only while reset is held, and it raises `out_ready` for a single cycle after it has checked a held opcode. Each instruction is driven byte by byte, with `in_valid` dropped once the opcode has been sent.

// File: rtl/pfx_pkg.sv
// Package: shared types and decode helpers for the prefix scanner.
// Assumes byte-wide instruction streams.
package pfx_pkg;

    localparam int BYTE_W = 8;
    localparam int SEG_W  = 3;
    localparam logic [SEG_W-1:0] SEG_DEFAULT = 3'd3;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } size_e;

    // Classification of one incoming byte
    typedef struct packed {
        logic             is_pfx;
        logic             is_seg;
        logic [SEG_W-1:0] seg;
        logic             is_osz;
        logic             is_asz;
        logic             is_lock;
        logic             is_rep;
        logic             is_ext;
    } pfx_class_t;

    // Prefix state gathered for the instruction in flight
    typedef struct packed {
        logic             seg_ovr;
        logic [SEG_W-1:0] seg;
        logic             osz;
        logic             asz;
        logic             lock;
        logic             rep;
        logic [3:0]       ext;
    } pfx_state_t;

    // True for opcodes whose operand is a single byte
    function automatic logic is_byte_op(input logic [BYTE_W-1:0] op);
        logic low_alu;
        low_alu = (op < 8'h40) &&
                  ((op[2:0] == 3'd0) || (op[2:0] == 3'd2) || (op[2:0] == 3'd4));
        return low_alu || (op == 8'h88) || (op == 8'h8A) || (op == 8'hC6) ||
               (op == 8'hA0) || (op == 8'hA2) || (op[7:3] == 5'b10110);
    endfunction

endpackage

// File: rtl/pfx_classify.sv
// Module: pfx_classify
// Decodes one byte into prefix categories. Pure combinational.
// Assumes mode64 is static; extension bytes count as prefixes only in 64-bit mode.
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              mode64,
    output pfx_class_t        cls
);

    // Map the byte to its prefix category
    always_comb begin
        cls = '0;
        unique case (byte_i)
            8'h26: begin cls.is_seg = 1'b1; cls.seg = 3'd0; end
            8'h2E: begin cls.is_seg = 1'b1; cls.seg = 3'd1; end
            8'h36: begin cls.is_seg = 1'b1; cls.seg = 3'd2; end
            8'h3E: begin cls.is_seg = 1'b1; cls.seg = 3'd3; end
            8'h64: begin cls.is_seg = 1'b1; cls.seg = 3'd4; end
            8'h65: begin cls.is_seg = 1'b1; cls.seg = 3'd5; end
            8'h66: cls.is_osz  = 1'b1;
            8'h67: cls.is_asz  = 1'b1;
            8'hF0: cls.is_lock = 1'b1;
            8'hF2, 8'hF3: cls.is_rep = 1'b1;
            default: cls.is_ext = mode64 && (byte_i[7:4] == 4'h4);
        endcase
        cls.is_pfx = cls.is_seg | cls.is_osz | cls.is_asz |
                     cls.is_lock | cls.is_rep | cls.is_ext;
    end

endmodule

// File: rtl/pfx_accum.sv
// Module: pfx_accum
// Holds the prefix state for the instruction being scanned.
// An extension prefix survives only while no other prefix follows it.
// Assumes take_pfx and take_op are never high together.
module pfx_accum
    import pfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_pfx,
    input  logic              take_op,
    input  pfx_class_t        cls,
    input  logic [BYTE_W-1:0] byte_i,
    output pfx_state_t        st
);

    pfx_state_t st_q;

    // Update or clear the prefix state on each accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n || take_op) begin
            st_q     <= '0;
            st_q.seg <= SEG_DEFAULT;
        end else if (take_pfx) begin
            if (cls.is_ext) begin
                st_q.ext <= byte_i[3:0];
            end else begin
                st_q.ext <= 4'd0;
                if (cls.is_seg) begin
                    st_q.seg_ovr <= 1'b1;
                    st_q.seg     <= cls.seg;
                end
                if (cls.is_osz)  st_q.osz  <= 1'b1;
                if (cls.is_asz)  st_q.asz  <= 1'b1;
                if (cls.is_lock) st_q.lock <= 1'b1;
                if (cls.is_rep)  st_q.rep  <= 1'b1;
            end
        end
    end

    assign st = st_q;

endmodule

// File: rtl/pfx_size.sv
// Module: pfx_size
// Resolves operand and address size from mode, prefixes and opcode class.
// Pure combinational.
module pfx_size
    import pfx_pkg::*;
(
    input  logic              mode64,
    input  pfx_state_t        st,
    input  logic [BYTE_W-1:0] opcode,
    output size_e             op_sz,
    output size_e             ad_sz
);

    // Operand size: byte class, then wide bit, then 0x66
    always_comb begin
        if (is_byte_op(opcode))
            op_sz = SZ8;
        else if (mode64 && st.ext[3])
            op_sz = SZ64;
        else if (st.osz)
            op_sz = SZ16;
        else
            op_sz = SZ32;
    end

    // Address size: mode default, halved by 0x67
    always_comb begin
        if (mode64)
            ad_sz = st.asz ? SZ32 : SZ64;
        else
            ad_sz = st.asz ? SZ16 : SZ32;
    end

endmodule

// File: rtl/pfx_scanner.sv
// Module: pfx_scanner (top)
// Consumes prefix bytes, then registers the opcode with its resolved
// attributes and holds them until out_ready. Synchronous active-low reset.
// Assumes mode64 changes only while reset is asserted.
module pfx_scanner
    import pfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode64,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              op_valid,
    output logic [BYTE_W-1:0] op_byte,
    input  logic              out_ready,
    output logic              seg_ovr,
    output logic [SEG_W-1:0]  seg_sel,
    output logic              lock_seen,
    output logic              rep_seen,
    output logic [1:0]        op_size,
    output logic [1:0]        addr_size,
    output logic              ext_wide,
    output logic              ext_reg,
    output logic              ext_idx,
    output logic              ext_base
);

    pfx_class_t cls;
    pfx_state_t st;
    size_e      op_sz, ad_sz;
    logic       accept, take_pfx, take_op;

    pfx_classify u_cls (.byte_i(in_byte), .mode64(mode64), .cls(cls));

    // Accept handshake and split between prefix and opcode
    always_comb begin
        in_ready = !op_valid || out_ready;
        accept   = in_valid && in_ready;
        take_pfx = accept && cls.is_pfx;
        take_op  = accept && !cls.is_pfx;
    end

    pfx_accum u_acc (
        .clk(clk), .rst_n(rst_n), .take_pfx(take_pfx), .take_op(take_op),
        .cls(cls), .byte_i(in_byte), .st(st)
    );

    pfx_size u_sz (
        .mode64(mode64), .st(st), .opcode(in_byte), .op_sz(op_sz), .ad_sz(ad_sz)
    );

    // Register opcode attributes and manage the valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid  <= 1'b0;
            op_byte   <= '0;
            seg_ovr   <= 1'b0;
            seg_sel   <= SEG_DEFAULT;
            lock_seen <= 1'b0;
            rep_seen  <= 1'b0;
            op_size   <= SZ32;
            addr_size <= SZ32;
            {ext_wide, ext_reg, ext_idx, ext_base} <= 4'd0;
        end else if (take_op) begin
            op_valid  <= 1'b1;
            op_byte   <= in_byte;
            seg_ovr   <= st.seg_ovr;
            seg_sel   <= st.seg;
            lock_seen <= st.lock;
            rep_seen  <= st.rep;
            op_size   <= op_sz;
            addr_size <= ad_sz;
            {ext_wide, ext_reg, ext_idx, ext_base} <= st.ext;
        end else if (out_ready) begin
            op_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/pfx_scanner_chk.sv
// Module: pfx_scanner_chk
// Checker bound to pfx_scanner; observes ports only.
module pfx_scanner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode64,
    input logic       in_ready,
    input logic       op_valid,
    input logic [7:0] op_byte,
    input logic       out_ready,
    input logic       seg_ovr,
    input logic [2:0] seg_sel,
    input logic [1:0] op_size,
    input logic [1:0] addr_size,
    input logic       ext_wide,
    input logic       ext_reg,
    input logic       ext_idx,
    input logic       ext_base
);

    // R1
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !out_ready) |-> !in_ready);

    // R1
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !out_ready) |=> (op_valid && $stable(op_byte) &&
            $stable(op_size) && $stable(addr_size) && $stable(seg_sel)));

    // R3
    seg_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !seg_ovr) |-> (seg_sel == 3'd3));

    // R3
    seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (seg_sel <= 3'd5));

    // R6
    addr_nonbyte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (addr_size != 2'd0));

    // R8
    no_ext32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !mode64) |-> ({ext_wide, ext_reg, ext_idx, ext_base} == 4'd0));

    // R5
    no_wide32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !mode64) |-> (op_size != 2'd3 && addr_size != 2'd3));

    // R12
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!op_valid && in_ready));

endmodule

bind pfx_scanner pfx_scanner_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .in_ready(in_ready),
    .op_valid(op_valid), .op_byte(op_byte), .out_ready(out_ready),
    .seg_ovr(seg_ovr), .seg_sel(seg_sel), .op_size(op_size),
    .addr_size(addr_size), .ext_wide(ext_wide), .ext_reg(ext_reg),
    .ext_idx(ext_idx), .ext_base(ext_base)
);

// File: tb/pfx_scanner_bench.sv
// Directed bench for pfx_scanner: one task per scenario.
module pfx_scanner_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode64 = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_ready = 1'b0;
    logic       in_ready, op_valid, seg_ovr, lock_seen, rep_seen;
    logic       ext_wide, ext_reg, ext_idx, ext_base;
    logic [7:0] op_byte;
    logic [2:0] seg_sel;
    logic [1:0] op_size, addr_size;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pfx_scanner u_pfx_scanner (
        .clk(clk), .rst_n(rst_n), .mode64(mode64), .in_valid(in_valid),
        .in_byte(in_byte), .in_ready(in_ready), .op_valid(op_valid),
        .op_byte(op_byte), .out_ready(out_ready), .seg_ovr(seg_ovr),
        .seg_sel(seg_sel), .lock_seen(lock_seen), .rep_seen(rep_seen),
        .op_size(op_size), .addr_size(addr_size), .ext_wide(ext_wide),
        .ext_reg(ext_reg), .ext_idx(ext_idx), .ext_base(ext_base)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic restart(input logic m);
        @(negedge clk);
        rst_n = 1'b0; mode64 = m; in_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Send n bytes (first byte in the most significant used position),
    // then check the held opcode and its release.
    task automatic run_instr(input string tag, input int n, input logic [47:0] seq,
                             input logic [7:0] e_op, input logic [1:0] e_osz,
                             input logic [1:0] e_asz, input logic e_sov,
                             input logic [2:0] e_seg, input logic e_lock,
                             input logic e_rep, input logic [3:0] e_ext);
        logic early = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (op_valid) early = 1'b1;
            in_valid = 1'b1;
            in_byte  = seq[8*(n-1-i) +: 8];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R2 no early op_valid"}, {7'd0, early}, 8'd0);
        chk({tag, " R2 op_valid"}, {7'd0, op_valid}, 8'd1);
        chk({tag, " R2 op_byte"}, op_byte, e_op);
        chk({tag, " op_size"}, {6'd0, op_size}, {6'd0, e_osz});
        chk({tag, " addr_size"}, {6'd0, addr_size}, {6'd0, e_asz});
        chk({tag, " R3 seg_ovr"}, {7'd0, seg_ovr}, {7'd0, e_sov});
        chk({tag, " R3 seg_sel"}, {5'd0, seg_sel}, {5'd0, e_seg});
        chk({tag, " R4 lock/rep"}, {6'd0, lock_seen, rep_seen}, {6'd0, e_lock, e_rep});
        chk({tag, " ext bits"}, {4'd0, ext_wide, ext_reg, ext_idx, ext_base}, {4'd0, e_ext});
        repeat (2) @(negedge clk);
        chk({tag, " R1 in_ready low while held"}, {7'd0, in_ready}, 8'd0);
        chk({tag, " R1 op_byte held"}, op_byte, e_op);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk({tag, " R1 op_valid released"}, {7'd0, op_valid}, 8'd0);
    endtask

    task automatic t_reset;
        restart(1'b0);
        chk("R12 op_valid after reset", {7'd0, op_valid}, 8'd0);
        chk("R12 in_ready after reset", {7'd0, in_ready}, 8'd1);
    endtask

    task automatic t_mode32;
        restart(1'b0);
        run_instr("R5 R6 plain", 1, 48'h8B, 8'h8B, 2'd2, 2'd2, 1'b0, 3'd3, 1'b0, 1'b0, 4'h0);
        run_instr("R3 R10 seg byte", 2, 48'h26C6, 8'hC6, 2'd0, 2'd2, 1'b1, 3'd0, 1'b0, 1'b0, 4'h0);
        run_instr("R5 R6 halves", 3, 48'h666789, 8'h89, 2'd1, 2'd1, 1'b0, 3'd3, 1'b0, 1'b0, 4'h0);
        run_instr("R8 ext as opcode", 1, 48'h41, 8'h41, 2'd2, 2'd2, 1'b0, 3'd3, 1'b0, 1'b0, 4'h0);
        run_instr("R3 R4 last seg", 5, 48'hF0F32E6501, 8'h01, 2'd2, 2'd2, 1'b1, 3'd5, 1'b1, 1'b1, 4'h0);
        run_instr("R11 clean after", 1, 48'h89, 8'h89, 2'd2, 2'd2, 1'b0, 3'd3, 1'b0, 1'b0, 4'h0);
    endtask

    task automatic t_mode64;
        restart(1'b1);
        run_instr("R7 wide", 2, 48'h488B, 8'h8B, 2'd3, 2'd3, 1'b0, 3'd3, 1'b0, 1'b0, 4'h8);
        run_instr("R7 R10 base byte", 2, 48'h41C6, 8'hC6, 2'd0, 2'd3, 1'b0, 3'd3, 1'b0, 1'b0, 4'h1);
        run_instr("R7 wide beats 66", 3, 48'h664889, 8'h89, 2'd3, 2'd3, 1'b0, 3'd3, 1'b0, 1'b0, 4'h8);
        run_instr("R9 R5 ext discarded", 3, 48'h486689, 8'h89, 2'd1, 2'd3, 1'b0, 3'd3, 1'b0, 1'b0, 4'h0);
        run_instr("R9 R6 ext replaced", 4, 48'h67444C8B, 8'h8B, 2'd3, 2'd2, 1'b0, 3'd3, 1'b0, 1'b0, 4'hC);
        run_instr("R11 clean after", 1, 48'h8B, 8'h8B, 2'd2, 2'd3, 1'b0, 3'd3, 1'b0, 1'b0, 4'h0);
    endtask

    initial begin
        t_reset();
        t_mode32();
        t_mode64();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule